// File: doc/BRIEF.md
# Input Channel Switching Controller

This block produces the control lines for an analog two-input switch in front of a sampling converter. Software-style requests pick one of four ways of using the inputs: first input only, second input only, both inputs summed, or the two inputs taken in turn. In the alternating mode a toggle register changes the selected input once per save period. The save period is marked by a strobe that comes either straight from the save clock or from a delayed save clock. The delayed copy is first re-captured on the sampling clock.

The range field chooses between the two strobes. The direct save clock is used only on the fastest ranges. On every slower range the re-captured delayed copy is used, so that the switch point lines up with the longer pipeline delay. In min-max capture mode the strobe is divided by two. This keeps all samples compared within one save period on the same input.

All logic runs on one system clock. The save clock, delayed save clock and sampling clock arrive as levels, and their rising edges are detected inside the block.

Top module: `chsw_ctrl`

## Requirements
- R1: While `ch1_req_n` is low, `chan_sel` is 0 (first input) one clock later. This request wins over a simultaneous low `ch2_req_n`.
- R2: While `ch2_req_n` is low and `ch1_req_n` is high and `add_req` is low, `chan_sel` is 1 (second input) one clock later.
- R3: While `add_req` is high, `add_out` is 1 and `chan_sel` is 0 one clock later. `add_out` is 0 one clock after `add_req` is low.
- R4: With `alt_mode`=1, `acq_en`=1, `minmax_mode`=0 and `range_sel`=2'b11, each rising edge of `save_clk` flips `chan_sel` at the next clock edge. `tog_out` is high for exactly that one cycle.
- R5: With `range_sel` not equal to 2'b11, the switching strobe is the delayed save level captured on a rising edge of `smp_clk`. `chan_sel` flips one clock after that capture first shows a rising level. `save_clk` edges have no effect.
- R6: With `range_sel`=2'b11, `dly_save_clk` and `smp_clk` have no effect on `chan_sel`.
- R7: With `minmax_mode`=1, after `acq_en` rises, the first selected strobe edge does not flip `chan_sel`, the second does, and the pattern repeats every two edges.
- R8: While `acq_en` is low, strobe edges do not flip `chan_sel` and `tog_out` stays 0. The min-max divide phase is cleared.
- R9: Changing `range_sel` while `acq_en` is low, with all clock levels held, causes no flip of `chan_sel` after `acq_en` rises again.
- R10: After reset, `chan_sel`, `add_out` and `tog_out` are 0.
- R11: With `alt_mode`=0 and no request active, strobe edges leave `chan_sel` unchanged and `tog_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch1_req_n | input | 1 | Active-low request to select the first input |
| ch2_req_n | input | 1 | Active-low request to select the second input |
| add_req | input | 1 | Request to sum both inputs |
| alt_mode | input | 1 | Alternate between the inputs once per strobe |
| minmax_mode | input | 1 | Divide the switching strobe by two |
| acq_en | input | 1 | Acquisition running; enables toggling |
| range_sel | input | 2 | Timebase range field; 2'b11 selects the direct save clock |
| save_clk | input | 1 | Save clock level |
| dly_save_clk | input | 1 | Delayed save clock level |
| smp_clk | input | 1 | Sampling clock level |
| chan_sel | output | 1 | Switch select: 0 first input, 1 second input |
| add_out | output | 1 | Sum-both-inputs line |
| tog_out | output | 1 | One-cycle pulse on each alternation step |

## Verification
If the toggle register holds the wrong value, the fault shows at `chan_sel` and `tog_out` on the clock edge after the next strobe. If the min-max divide phase is wrong, the flip happens one strobe early or late, on the first or second edge after enable. If the re-capture flop is wrong, the flip in the slow ranges moves by one clock or follows `save_clk` by mistake, and both show within two clocks of the sampling edge. If a request is lost, the fault shows one clock after the request is applied.

// File: rtl/chsw_pkg.sv
package chsw_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ADD  = 2'd1,
    SRC_IN1  = 2'd2,
    SRC_IN2  = 2'd3
  } force_src_e;

  // Request priority: summing, then first input, then second input.
  function automatic force_src_e pick_force(input logic add_r,
                                            input logic in1_n,
                                            input logic in2_n);
    if (add_r)       return SRC_ADD;
    else if (!in1_n) return SRC_IN1;
    else if (!in2_n) return SRC_IN2;
    else             return SRC_NONE;
  endfunction

  // Next value of the switch select given the forcing source and a step.
  function automatic logic next_sel(input force_src_e src,
                                    input logic cur,
                                    input logic step);
    case (src)
      SRC_ADD: return 1'b0;
      SRC_IN1: return 1'b0;
      SRC_IN2: return 1'b1;
      default: return step ? ~cur : cur;
    endcase
  endfunction

  // Fastest range code: every bit of the field high.
  function automatic logic is_fast(input logic [1:0] rng);
    return &rng;
  endfunction

endpackage

// File: rtl/chsw_rise.sv
module chsw_rise #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] lvl_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) lvl_q[i] <= 1'b0;
      else        lvl_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~lvl_q[i];
  end
endmodule

// File: rtl/chsw_clksel.sv
module chsw_clksel
  import chsw_pkg::*;
#(
  parameter int RNG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RNG_W-1:0] range_sel,
  input  logic             save_clk,
  input  logic             dly_save_clk,
  input  logic             smp_clk,
  output logic             sel_rise
);
  logic [1:0] raw_rise;
  logic       retimed_q;
  logic       rt_rise;
  logic       fast_rng;

  chsw_rise #(.W(2)) i_raw (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({smp_clk, save_clk}),
    .rise (raw_rise)
  );

  // Delayed save level re-captured on a sampling clock rising edge.
  always_ff @(posedge clk) begin
    if (!rst_n)           retimed_q <= 1'b0;
    else if (raw_rise[1]) retimed_q <= dly_save_clk;
  end

  chsw_rise #(.W(1)) i_rt (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (retimed_q),
    .rise (rt_rise)
  );

  assign fast_rng = is_fast(range_sel[1:0]);
  assign sel_rise = fast_rng ? raw_rise[0] : rt_rise;

  // R6: on the fast range only the direct save edge may produce a strobe
  p_fast_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_rng && sel_rise) |-> (save_clk && !$past(save_clk)));

  // R5: on slow ranges a strobe needs the re-captured level to have risen
  p_slow_retimed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_rng && sel_rise) |-> (retimed_q && $rose(retimed_q)));
endmodule

// File: rtl/chsw_div.sv
module chsw_div (
  input  logic clk,
  input  logic rst_n,
  input  logic acq_en,
  input  logic minmax_mode,
  input  logic sel_rise,
  output logic advance
);
  logic half_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !acq_en) half_q <= 1'b0;
    else if (sel_rise)     half_q <= ~half_q;
  end

  assign advance = acq_en & sel_rise & (~minmax_mode | half_q);

  // R8: no step while acquisition is stopped
  p_no_step_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !acq_en |-> !advance);

  // R7: in min-max mode a strobe on the even phase does not step
  p_half_rate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (minmax_mode && sel_rise && !half_q) |-> !advance);
endmodule

// File: rtl/chsw_ctrl.sv
module chsw_ctrl
  import chsw_pkg::*;
#(
  parameter int RNG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ch1_req_n,
  input  logic             ch2_req_n,
  input  logic             add_req,
  input  logic             alt_mode,
  input  logic             minmax_mode,
  input  logic             acq_en,
  input  logic [RNG_W-1:0] range_sel,
  input  logic             save_clk,
  input  logic             dly_save_clk,
  input  logic             smp_clk,
  output logic             chan_sel,
  output logic             add_out,
  output logic             tog_out
);
  logic       sel_rise;
  logic       advance;
  logic       step;
  force_src_e src;
  logic       sel_q;
  logic       add_q;
  logic       tog_q;

  chsw_clksel #(.RNG_W(RNG_W)) i_clksel (
    .clk         (clk),
    .rst_n       (rst_n),
    .range_sel   (range_sel),
    .save_clk    (save_clk),
    .dly_save_clk(dly_save_clk),
    .smp_clk     (smp_clk),
    .sel_rise    (sel_rise)
  );

  chsw_div i_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .acq_en     (acq_en),
    .minmax_mode(minmax_mode),
    .sel_rise   (sel_rise),
    .advance    (advance)
  );

  assign src  = pick_force(add_req, ch1_req_n, ch2_req_n);
  assign step = advance & alt_mode & (src == SRC_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      add_q <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      sel_q <= next_sel(src, sel_q, step);
      add_q <= (src == SRC_ADD);
      tog_q <= step;
    end
  end

  assign chan_sel = sel_q;
  assign add_out  = add_q;
  assign tog_out  = tog_q;

  // R1: first-input request wins over the second-input request
  p_in1_force_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ch1_req_n |=> !chan_sel);

  // R2: second-input request alone selects the second input
  p_in2_force_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ch1_req_n && !ch2_req_n && !add_req) |=> chan_sel);

  // R3: summing drives the add line and parks the select low
  p_add_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    add_req |=> (add_out && !chan_sel));

  // R4: every step pulse coincides with a change of the select
  p_step_flips_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tog_out |-> (chan_sel != $past(chan_sel)));

  // R11: without alternation or requests the select holds
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!alt_mode && ch1_req_n && ch2_req_n && !add_req) |=> $stable(chan_sel));

  // R8: stopped acquisition with no request keeps the select
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!acq_en && ch1_req_n && ch2_req_n && !add_req) |=> ($stable(chan_sel) && !tog_out));

  // R10: reset clears all outputs
  p_reset_r10: assert property (@(posedge clk)
    !rst_n |=> (!chan_sel && !add_out && !tog_out));
endmodule

// File: tb/test_chsw_ctrl.sv
module test_chsw_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ch1_req_n, ch2_req_n, add_req, alt_mode, minmax_mode, acq_en;
  logic [1:0] range_sel;
  logic       save_clk, dly_save_clk, smp_clk;
  logic       chan_sel, add_out, tog_out;

  int n_run  = 0;
  int n_fail = 0;
  logic exp_sel;

  always #10 clk = ~clk;

  chsw_ctrl i_chsw_ctrl (
    .clk(clk), .rst_n(rst_n), .ch1_req_n(ch1_req_n), .ch2_req_n(ch2_req_n),
    .add_req(add_req), .alt_mode(alt_mode), .minmax_mode(minmax_mode),
    .acq_en(acq_en), .range_sel(range_sel), .save_clk(save_clk),
    .dly_save_clk(dly_save_clk), .smp_clk(smp_clk),
    .chan_sel(chan_sel), .add_out(add_out), .tog_out(tog_out)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Save clock pulse; the flip (if any) shows after the first edge.
  task automatic pulse_save(input string tag, input logic flips);
    save_clk = 1'b1;
    step();
    if (flips) exp_sel = ~exp_sel;
    chk({tag, " sel"}, chan_sel, exp_sel);
    chk({tag, " tog"}, tog_out, flips);
    save_clk = 1'b0;
    step();
    chk({tag, " tog end"}, tog_out, 1'b0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ch1_req_n = 1'b1; ch2_req_n = 1'b1; add_req = 1'b0;
    alt_mode = 1'b0; minmax_mode = 1'b0; acq_en = 1'b0; range_sel = 2'b11;
    save_clk = 1'b0; dly_save_clk = 1'b0; smp_clk = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R10 sel", chan_sel, 1'b0);
    chk("R10 add", add_out, 1'b0);
    chk("R10 tog", tog_out, 1'b0);
  endtask

  task automatic t_requests();
    ch1_req_n = 1'b0; ch2_req_n = 1'b0;
    step();
    chk("R1 in1 beats in2", chan_sel, 1'b0);
    ch1_req_n = 1'b1;
    step();
    chk("R2 in2 select", chan_sel, 1'b1);
    ch2_req_n = 1'b1; add_req = 1'b1;
    step();
    chk("R3 add line", add_out, 1'b1);
    chk("R3 sel low", chan_sel, 1'b0);
    add_req = 1'b0;
    step();
    chk("R3 add release", add_out, 1'b0);
    exp_sel = 1'b0;
  endtask

  task automatic t_fast_alt();
    range_sel = 2'b11; alt_mode = 1'b1; acq_en = 1'b1;
    step();
    pulse_save("R4 first", 1'b1);
    pulse_save("R4 second", 1'b1);
    // R6: delayed path activity is ignored on the fast range
    dly_save_clk = 1'b1; smp_clk = 1'b1; step(); smp_clk = 1'b0; step(); step();
    chk("R6 sel", chan_sel, exp_sel);
    chk("R6 tog", tog_out, 1'b0);
    dly_save_clk = 1'b0; smp_clk = 1'b1; step(); smp_clk = 1'b0; step();
    chk("R6 sel after", chan_sel, exp_sel);
  endtask

  task automatic t_slow_alt();
    acq_en = 1'b0; step();
    range_sel = 2'b01; step();
    acq_en = 1'b1; step();
    pulse_save("R5 save ignored", 1'b0);
    dly_save_clk = 1'b1; smp_clk = 1'b1;
    step();
    chk("R5 capture edge", chan_sel, exp_sel);
    step();
    exp_sel = ~exp_sel;
    chk("R5 flip", chan_sel, exp_sel);
    chk("R5 tog", tog_out, 1'b1);
    smp_clk = 1'b0; step();
    chk("R5 tog end", tog_out, 1'b0);
    dly_save_clk = 1'b0; smp_clk = 1'b1; step(); smp_clk = 1'b0; step(); step();
    chk("R5 low capture", chan_sel, exp_sel);
  endtask

  task automatic t_minmax();
    acq_en = 1'b0; range_sel = 2'b11; minmax_mode = 1'b1; step();
    acq_en = 1'b1; step();
    pulse_save("R7 edge1", 1'b0);
    pulse_save("R7 edge2", 1'b1);
    pulse_save("R7 edge3", 1'b0);
    pulse_save("R7 edge4", 1'b1);
    minmax_mode = 1'b0;
  endtask

  task automatic t_idle();
    acq_en = 1'b0; step();
    pulse_save("R8 idle", 1'b0);
    acq_en = 1'b1; minmax_mode = 1'b1; step();
    pulse_save("R8 phase cleared edge1", 1'b0);
    pulse_save("R8 phase cleared edge2", 1'b1);
    minmax_mode = 1'b0;
  endtask

  task automatic t_range_swap();
    acq_en = 1'b0; range_sel = 2'b11;
    save_clk = 1'b1; dly_save_clk = 1'b1; step();
    smp_clk = 1'b1; step(); step();
    range_sel = 2'b10; step();
    acq_en = 1'b1; step(); step(); step();
    chk("R9 to slow sel", chan_sel, exp_sel);
    chk("R9 to slow tog", tog_out, 1'b0);
    acq_en = 1'b0; step();
    range_sel = 2'b11; step();
    acq_en = 1'b1; step(); step(); step();
    chk("R9 to fast sel", chan_sel, exp_sel);
    save_clk = 1'b0; dly_save_clk = 1'b0; smp_clk = 1'b0; step(); step();
  endtask

  task automatic t_no_alt();
    alt_mode = 1'b0; step();
    pulse_save("R11 hold", 1'b0);
    pulse_save("R11 hold again", 1'b0);
  endtask

  initial begin
    exp_sel = 1'b0;
    t_reset();
    t_requests();
    t_fast_alt();
    t_slow_alt();
    t_minmax();
    t_idle();
    t_range_swap();
    t_no_alt();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule